// File: doc/BRIEF.md
# Eight-Bit Compare and Capture Timer Channel

This block is one channel of an 8-bit general-purpose timer. An up-counter advances once per count-enable tick and is compared against two constant registers, A and B. Register B works either as a second compare register or, in capture mode, as a register that latches the counter when a chosen edge appears on the capture pin. Three sticky status flags record a match on A, a match or capture on B, and a counter wrap. Software can clear a flag only by reading it while it is set and then writing 0 to it.

Each match drives the timer output pin through its own two-bit action field (keep, drive low, drive high, toggle), and match B takes priority when both fire together. A start request for an A/D converter is formed from an enable input owned by the converter, a gate bit in this channel, and either match A or an external trigger. A small synchronous register bus reaches all state.

Top module: `cmp_cap_timer8`

## Requirements
- R1: The counter resets to 0x00, adds one (wrapping modulo 256) on each clock edge where tick_i is high, and takes the written value instead when a counter write falls in the same cycle as a tick.
- R2: A tick that moves the counter from 0xFF to 0x00 sets the overflow flag (status bit 2) at that same edge.
- R3: A tick that moves the counter onto the value of register A sets the A flag (status bit 0); a bus write to the counter never counts as a match.
- R4: In compare mode (control bit 4 = 0), a tick that moves the counter onto the value of register B sets the B flag (status bit 1).
- R5: In capture mode (control bit 4 = 1), a selected edge on cap_i copies the counter into register B and sets the B flag on the third rising clock edge after cap_i changes (two synchroniser stages plus edge detection).
- R6: Control bits [6:5] pick the capture edge: 00 rising, 01 falling, 10 or 11 both; edges not selected leave register B and the B flag unchanged.
- R7: A flag goes to 0 only when a status write carries 0 in its bit after a status read that saw the flag at 1; any status write consumes that read, and writing 1, or writing 0 without a prior read, leaves the flag unchanged.
- R8: A flag event in the same cycle as a valid clearing write wins: the flag stays 1.
- R9: Control bits [1:0] (match A) and [3:2] (match B) select the pin action on a match: 00 keep, 01 drive 0, 10 drive 1, 11 toggle; the pin resets to 0 and does not change without a match.
- R10: When A and B match in the same cycle and B's action is not keep, B's action is applied; if B's action is keep, A's action is applied.
- R11: adc_start_o is a one-cycle pulse asserted after the edge of the trigger event: never while trge_i is 0; with trge_i = 1 and control bit 7 = 0 only from ext_trig_i; with trge_i = 1 and control bit 7 = 1 only from match A.
- R12: Register addresses are 0 control, 1 status, 2 counter, 3 register A, 4 register B; rdata_o shows the addressed register combinationally; registers A and B reset to 0xFF, control and status to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe, arms flag clearing |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data of the addressed register |
| tick_i | input | 1 | Count-enable tick |
| cap_i | input | 1 | Asynchronous capture pin |
| ext_trig_i | input | 1 | External A/D trigger, one-cycle synchronous pulse |
| trge_i | input | 1 | A/D trigger enable from the converter |
| tmr_o | output | 1 | Timer output pin |
| adc_start_o | output | 1 | A/D start pulse |

## Verification
The two functions that can meet in one cycle are a flag being set by the counter and the bus write that clears it. The bench arms the overflow flag with a status read, loads the counter with 0xFF, and issues the clearing write in the very cycle a tick wraps the counter; the flag must read 1 afterwards, and a later plain read-then-write must clear it. The match A and match B coincidence is also forced by giving both registers the same value, with conflicting actions chosen so the pin level shows which one won.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 3;
  localparam int unsigned NFLAG = 3;
  localparam int unsigned FLAG_A   = 0;
  localparam int unsigned FLAG_B   = 1;
  localparam int unsigned FLAG_OVF = 2;

  localparam logic [AW-1:0] ADDR_CTRL = 3'd0;
  localparam logic [AW-1:0] ADDR_STAT = 3'd1;
  localparam logic [AW-1:0] ADDR_CNT  = 3'd2;
  localparam logic [AW-1:0] ADDR_CA   = 3'd3;
  localparam logic [AW-1:0] ADDR_CB   = 3'd4;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  typedef struct packed {
    logic       adte;
    logic [1:0] cap_edge;
    logic       cap_en;
    pin_act_e   act_b;
    pin_act_e   act_a;
  } ctrl_t;
endpackage

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr8_flag.sv
module tmr8_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)                         flag_q <= 1'b1;
      else if (wr_i && arm_q && !wbit_i) flag_q <= 1'b0;
      if (wr_i)                          arm_q  <= 1'b0;
      else if (rd_i && flag_q)           arm_q  <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  // R7
  clr_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(arm_q) && $past(wr_i) && !$past(wbit_i));
  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/tmr8_pin.sv
module tmr8_pin
  import tmr8_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hit_a_i,
  input  logic     hit_b_i,
  input  pin_act_e act_a_i,
  input  pin_act_e act_b_i,
  output logic     pin_o
);
  pin_act_e act;
  logic     pin_q;

  always_comb begin
    act = ACT_KEEP;
    if (hit_a_i) act = act_a_i;
    if (hit_b_i && act_b_i != ACT_KEEP) act = act_b_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else begin
      case (act)
        ACT_LOW:    pin_q <= 1'b0;
        ACT_HIGH:   pin_q <= 1'b1;
        ACT_TOGGLE: pin_q <= ~pin_q;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;

  // R9
  pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_a_i && !hit_b_i |=> $stable(pin_q));
  // R10
  b_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_a_i && hit_b_i && act_b_i == ACT_HIGH |=> pin_q);
endmodule

// File: rtl/cmp_cap_timer8.sv
module cmp_cap_timer8
  import tmr8_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          wr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_i,
  input  logic          cap_i,
  input  logic          ext_trig_i,
  input  logic          trge_i,
  output logic          tmr_o,
  output logic          adc_start_o
);
  ctrl_t            ctrl_q;
  logic [DW-1:0]    cnt_q, cora_q, corb_q, cnt_inc;
  logic [NFLAG-1:0] flag, flag_set;
  logic             wr_ctrl, wr_stat, wr_cnt, wr_ca, wr_cb, rd_stat;
  logic             adv, hit_a, hit_b, wrap, rise, fall, cap_ev, start_q;

  assign wr_ctrl = wr_i && addr_i == ADDR_CTRL;
  assign wr_stat = wr_i && addr_i == ADDR_STAT;
  assign wr_cnt  = wr_i && addr_i == ADDR_CNT;
  assign wr_ca   = wr_i && addr_i == ADDR_CA;
  assign wr_cb   = wr_i && addr_i == ADDR_CB;
  assign rd_stat = rd_i && addr_i == ADDR_STAT;

  // a bus load of the counter beats the tick and never counts as a match
  assign adv     = tick_i && !wr_cnt;
  assign cnt_inc = cnt_q + 1'b1;
  assign hit_a   = adv && cnt_inc == cora_q;
  assign hit_b   = adv && !ctrl_q.cap_en && cnt_inc == corb_q;
  assign wrap    = adv && cnt_q == '1;

  tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i(cap_i), .rise_o(rise), .fall_o(fall)
  );

  always_comb begin
    if (ctrl_q.cap_edge[1])      cap_ev = rise | fall;
    else if (ctrl_q.cap_edge[0]) cap_ev = fall;
    else                         cap_ev = rise;
    cap_ev = cap_ev && ctrl_q.cap_en;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      cnt_q   <= '0;
      cora_q  <= '1;
      corb_q  <= '1;
      start_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i);
      if (wr_cnt)   cnt_q <= wdata_i;
      else if (adv) cnt_q <= cnt_inc;
      if (wr_ca) cora_q <= wdata_i;
      if (cap_ev)     corb_q <= cnt_q;
      else if (wr_cb) corb_q <= wdata_i;
      start_q <= trge_i && (ctrl_q.adte ? hit_a : ext_trig_i);
    end
  end

  assign flag_set[FLAG_A]   = hit_a;
  assign flag_set[FLAG_B]   = hit_b | cap_ev;
  assign flag_set[FLAG_OVF] = wrap;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    tmr8_flag u_flag (
      .clk_i, .rst_ni,
      .set_i (flag_set[g]),
      .rd_i  (rd_stat),
      .wr_i  (wr_stat),
      .wbit_i(wdata_i[g]),
      .flag_o(flag[g])
    );
  end

  tmr8_pin u_pin (
    .clk_i, .rst_ni,
    .hit_a_i(hit_a), .hit_b_i(hit_b),
    .act_a_i(ctrl_q.act_a), .act_b_i(ctrl_q.act_b),
    .pin_o  (tmr_o)
  );

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_STAT: rdata_o = {{(DW-NFLAG){1'b0}}, flag};
      ADDR_CNT:  rdata_o = cnt_q;
      ADDR_CA:   rdata_o = cora_q;
      ADDR_CB:   rdata_o = corb_q;
      default:   rdata_o = '0;
    endcase
  end

  assign adc_start_o = start_q;

  // R1
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> cnt_q == DW'($past(cnt_q) + 1'b1));
  // R2
  ovf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> cnt_q == '0 && flag[FLAG_OVF]);
  // R3
  match_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_a |=> flag[FLAG_A] && cnt_q == cora_q);
  // R5
  capture_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev |=> corb_q == $past(cnt_q) && flag[FLAG_B]);
  // R11
  adc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> $past(trge_i));
  // R11
  adc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trge_i |=> !adc_start_o);
endmodule

// File: tb/cmp_cap_timer8_test.sv
module cmp_cap_timer8_test;
  import tmr8_pkg::*;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, v;
  logic          rd = 0, wr = 0, tick = 0, cap = 0, ext = 0, trge = 0;
  logic          tmr, adc;
  int            n_chk = 0, n_bad = 0, adc_cnt = 0, base;
  bit            done = 0;

  always #10 clk = ~clk;

  cmp_cap_timer8 uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .rd_i(rd), .wr_i(wr),
    .rdata_o(rdata), .tick_i(tick), .cap_i(cap), .ext_trig_i(ext), .trge_i(trge),
    .tmr_o(tmr), .adc_start_o(adc)
  );

  always @(negedge clk) if (adc) adc_cnt++;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [AW-1:0] a, logic [7:0] d, logic t = 1'b0);
    @(negedge clk); addr = a; wdata = d; wr = 1; tick = t;
    @(negedge clk); wr = 0; tick = 0;
  endtask

  task automatic rd_reg(logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic peek(logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic clear_flags();
    logic [7:0] t;
    rd_reg(ADDR_STAT, t);
    wr_reg(ADDR_STAT, 8'h00);
  endtask

  task automatic t_reset();
    peek(ADDR_CNT, v);  chk("R1 reset count", v, 8'h00);
    peek(ADDR_STAT, v); chk("R12 reset status", v, 8'h00);
    peek(ADDR_CTRL, v); chk("R12 reset control", v, 8'h00);
    peek(ADDR_CA, v);   chk("R12 reset A", v, 8'hFF);
    peek(ADDR_CB, v);   chk("R12 reset B", v, 8'hFF);
    chk("R9 reset pin", {7'd0, tmr}, 8'd0);
    chk("R11 reset adc", {7'd0, adc}, 8'd0);
  endtask

  task automatic t_count();
    wr_reg(ADDR_CA, 8'h40); wr_reg(ADDR_CB, 8'h40);
    wr_reg(ADDR_CNT, 8'hFD);
    peek(ADDR_CNT, v); chk("R12 counter write", v, 8'hFD);
    tick_n(3);
    peek(ADDR_CNT, v);  chk("R1 count wrap", v, 8'h00);
    peek(ADDR_STAT, v); chk("R2 overflow flag", v, 8'h04);
    wr_reg(ADDR_CNT, 8'h10, 1'b1);
    peek(ADDR_CNT, v); chk("R1 write beats tick", v, 8'h10);
    tick_n(1);
    peek(ADDR_CNT, v); chk("R1 single step", v, 8'h11);
  endtask

  task automatic t_clear();
    wr_reg(ADDR_STAT, 8'h00);
    peek(ADDR_STAT, v); chk("R7 write0 without read", v, 8'h04);
    rd_reg(ADDR_STAT, v);
    wr_reg(ADDR_STAT, 8'hFF);
    peek(ADDR_STAT, v); chk("R7 write1 no effect", v, 8'h04);
    wr_reg(ADDR_STAT, 8'h00);
    peek(ADDR_STAT, v); chk("R7 read consumed", v, 8'h04);
    rd_reg(ADDR_STAT, v);
    wr_reg(ADDR_STAT, 8'h00);
    peek(ADDR_STAT, v); chk("R7 read then write0", v, 8'h00);
  endtask

  task automatic t_cmp();
    wr_reg(ADDR_CA, 8'h05); wr_reg(ADDR_CB, 8'h0A);
    wr_reg(ADDR_CTRL, 8'h07);
    wr_reg(ADDR_CNT, 8'h00);
    tick_n(4);
    peek(ADDR_STAT, v); chk("R3 no early match", v, 8'h00);
    tick_n(1);
    peek(ADDR_STAT, v); chk("R3 match A flag", v, 8'h01);
    chk("R9 toggle on A", {7'd0, tmr}, 8'd1);
    tick_n(5);
    peek(ADDR_STAT, v); chk("R4 match B flag", v, 8'h03);
    chk("R9 drive0 on B", {7'd0, tmr}, 8'd0);
    wr_reg(ADDR_CTRL, 8'h02);
    wr_reg(ADDR_CNT, 8'h04); tick_n(1);
    chk("R9 drive1 on A", {7'd0, tmr}, 8'd1);
    wr_reg(ADDR_CTRL, 8'h00);
    wr_reg(ADDR_CNT, 8'h04); tick_n(1);
    chk("R9 keep on A", {7'd0, tmr}, 8'd1);
    wr_reg(ADDR_CTRL, 8'h0C);
    wr_reg(ADDR_CNT, 8'h09); tick_n(1);
    chk("R9 toggle on B", {7'd0, tmr}, 8'd0);
  endtask

  task automatic t_prio();
    clear_flags();
    wr_reg(ADDR_CA, 8'h20); wr_reg(ADDR_CB, 8'h20);
    wr_reg(ADDR_CTRL, 8'h09);
    wr_reg(ADDR_CNT, 8'h1F); tick_n(1);
    chk("R10 B action wins", {7'd0, tmr}, 8'd1);
    peek(ADDR_STAT, v); chk("R10 both flags", v, 8'h03);
    wr_reg(ADDR_CTRL, 8'h03);
    wr_reg(ADDR_CNT, 8'h1F); tick_n(1);
    chk("R10 A when B keeps", {7'd0, tmr}, 8'd0);
  endtask

  task automatic t_setwin();
    clear_flags();
    wr_reg(ADDR_CA, 8'h40); wr_reg(ADDR_CB, 8'h40); wr_reg(ADDR_CTRL, 8'h00);
    wr_reg(ADDR_CNT, 8'hFF); tick_n(1);
    rd_reg(ADDR_STAT, v); chk("R2 overflow before race", v, 8'h04);
    wr_reg(ADDR_CNT, 8'hFF);
    wr_reg(ADDR_STAT, 8'h00, 1'b1);
    peek(ADDR_STAT, v); chk("R8 set wins over clear", v, 8'h04);
    peek(ADDR_CNT, v);  chk("R1 wrap during clear", v, 8'h00);
    rd_reg(ADDR_STAT, v);
    wr_reg(ADDR_STAT, 8'h00);
    peek(ADDR_STAT, v); chk("R7 clear after race", v, 8'h00);
  endtask

  task automatic cap_to(logic lvl);
    @(negedge clk); cap = lvl;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_capture();
    clear_flags();
    wr_reg(ADDR_CTRL, 8'h10);
    wr_reg(ADDR_CNT, 8'h33);
    @(negedge clk); cap = 1; addr = ADDR_CB;
    @(posedge clk); @(posedge clk); @(negedge clk); #1;
    chk("R5 not yet captured", rdata, 8'h40);
    @(negedge clk); #1;
    chk("R5 captured on third edge", rdata, 8'h33);
    peek(ADDR_STAT, v); chk("R5 capture flag", v, 8'h02);
    clear_flags();
    wr_reg(ADDR_CNT, 8'h44);
    cap_to(0);
    peek(ADDR_CB, v);   chk("R6 rising mode ignores fall", v, 8'h33);
    peek(ADDR_STAT, v); chk("R6 no flag on fall", v, 8'h00);
    wr_reg(ADDR_CTRL, 8'h30);
    wr_reg(ADDR_CNT, 8'h55);
    cap_to(1);
    peek(ADDR_CB, v); chk("R6 falling mode ignores rise", v, 8'h33);
    cap_to(0);
    peek(ADDR_CB, v);   chk("R6 falling capture", v, 8'h55);
    peek(ADDR_STAT, v); chk("R6 falling flag", v, 8'h02);
    wr_reg(ADDR_CTRL, 8'h50);
    wr_reg(ADDR_CNT, 8'h66);
    cap_to(1);
    peek(ADDR_CB, v); chk("R6 both mode rise", v, 8'h66);
    wr_reg(ADDR_CNT, 8'h77);
    cap_to(0);
    peek(ADDR_CB, v); chk("R6 both mode fall", v, 8'h77);
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext = 1;
    @(negedge clk); ext = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hit_a_once();
    wr_reg(ADDR_CNT, 8'h0F); tick_n(1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_adc();
    wr_reg(ADDR_CTRL, 8'h00); wr_reg(ADDR_CA, 8'h10); wr_reg(ADDR_CB, 8'h40);
    trge = 0; base = adc_cnt;
    ext_pulse(); hit_a_once();
    chk("R11 disabled by trge", 8'(adc_cnt - base), 8'd0);
    trge = 1; base = adc_cnt;
    ext_pulse();
    chk("R11 external trigger", 8'(adc_cnt - base), 8'd1);
    base = adc_cnt; hit_a_once();
    chk("R11 match A gated off", 8'(adc_cnt - base), 8'd0);
    wr_reg(ADDR_CTRL, 8'h80);
    base = adc_cnt; ext_pulse();
    chk("R11 external gated off", 8'(adc_cnt - base), 8'd0);
    wr_reg(ADDR_CNT, 8'h0F);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    chk("R11 pulse after match edge", {7'd0, adc}, 8'd1);
    @(negedge clk);
    chk("R11 pulse one cycle", {7'd0, adc}, 8'd0);
    trge = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_clear();
    t_cmp();
    t_prio();
    t_setwin();
    t_capture();
    t_adc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule